// File: doc/BRIEF.md
# Multicart PRG Bank Address Generator

This block works out the 8 KiB program-ROM bank for every CPU read or write in the upper 32 KiB of the address space of a multicart mapper. An inner bank value arrives from a standard MMC3-style bank register file. Four outer configuration registers, already descrambled, select which part of the large ROM the current game sees. Under a variable mask the block merges an outer base with the inner bank. The mask is built from several outer-register bits, and it decides which bank bits follow the inner value and which come from the outer base.

A second mode emulates a simple discrete-logic board. In that mode the low bank bits come from an outer register and from the CPU address lines, which gives a fixed 16 KiB or 32 KiB window. An optional swap path serves games that expect their last two banks at the start of the window. When that path is active, inner values 0xFE and 0xFF are remapped to the first two banks of the window for accesses at $C000-$FFFF. The block has no state. Every output is a pure function of its inputs.

Top module: `prg_bank_gen`

## Requirements
- R1: The window mask has bits 3:0 set. Bit 4 is the inverse of outer0[6]. Bit 5 is the inverse of outer1[7]. Bit 6 equals outer1[6]. Bit 7 equals outer1[5].
- R2: The outer base is {outer0[5:4], outer1[3:2], outer1[4], outer0[2:0]}. Only its low nibble reaches the output, as bank bits 7:4, and only where the mask is clear.
- R3: When outer3[4]=0 (MMC3 mode), every bank bit whose mask bit is set equals the matching bit of the inner bank value. Every other bit comes from the shifted base.
- R4: When outer3[4]=1 (discrete mode), the mask is restricted to bits 7:4. Bits 7:4 of the bank then follow the R3 rule.
- R5: In discrete mode with outer1[1]=1 (32 KiB window), bank bits 3:2 equal outer3[3:2] and bank bit 1 equals CPU A14.
- R6: In discrete mode with outer1[1]=0 (16 KiB window), bank bits 3:1 equal outer3[3:1].
- R7: In discrete mode, bank bit 0 always equals CPU A13.
- R8: When outer3[6]=1, the command bit 6 input is 0, CPU A14=1 and the inner value is 0xFE or 0xFF, the inner value is replaced by 0x00 or 0x01 respectively before the merge.
- R9: The R8 remap is skipped when CPU A14=0, when command bit 6 is 1, when outer3[6]=0, or when the inner value is below 0xFE. In each of these cases the R3 result is produced unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_a14_i | input | 1 | CPU address bit 14 |
| cpu_a13_i | input | 1 | CPU address bit 13 |
| inner_bank_i | input | 8 | Inner bank value for the addressed slot |
| cmd_b6_i | input | 1 | Bit 6 of the inner bank-select command register |
| outer0_i | input | 8 | Outer register 0 (descrambled) |
| outer1_i | input | 8 | Outer register 1 (descrambled) |
| outer2_i | input | 8 | Outer register 2 (not used for program banks) |
| outer3_i | input | 8 | Outer register 3 (descrambled) |
| bank_o | output | 8 | Resulting 8 KiB program bank number |

## Verification
The bench builds the block with its default parameters: an 8-bit bank and the swap path enabled. With these settings every mask bit, both discrete window sizes and each of the four conditions that block the remap can be driven from the ports. Directed cases set the mask bits one at a time so that the base shows through the top bank bits. A sweep over the inner values and the address lines then compares the output with a model of the requirements.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int BANK_W  = 8;
  localparam int REG_W   = 8;
  localparam int NIB_W   = 4;
  localparam int BASE_SH = BANK_W - NIB_W;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [REG_W-1:0]  oreg_t;
endpackage

// File: rtl/prg_mask_gen.sv
module prg_mask_gen
  import prg_bank_pkg::*;
(
  input  oreg_t outer0_i,
  input  oreg_t outer1_i,
  input  logic  gnrom_i,
  output bank_t mask_o
);
  bank_t raw;

  always_comb begin
    raw    = bank_t'(8'h3F);
    raw[6] = outer1_i[6];
    raw[7] = outer1_i[5];
    raw[4] = raw[4] ^ outer0_i[6];
    raw[5] = raw[5] ^ outer1_i[7];
    mask_o = gnrom_i ? (raw & bank_t'(8'hF0)) : raw;
  end

  logic unused_mask_bits;
  assign unused_mask_bits = ^{outer0_i[7], outer0_i[5:0], outer1_i[4:0]};
endmodule

// File: rtl/prg_base_pack.sv
module prg_base_pack
  import prg_bank_pkg::*;
(
  input  oreg_t       outer0_i,
  input  oreg_t       outer1_i,
  output logic [7:0]  base_o
);
  assign base_o = {outer0_i[5:4], outer1_i[3:2], outer1_i[4], outer0_i[2:0]};

  logic unused_base_bits;
  assign unused_base_bits = ^{outer0_i[7:6], outer0_i[3], outer1_i[7:5], outer1_i[1:0]};
endmodule

// File: rtl/prg_bank_merge.sv
module prg_bank_merge
  import prg_bank_pkg::*;
(
  input  logic [7:0] base_i,
  input  bank_t      mask_i,
  input  bank_t      inner_i,
  input  logic       gnrom_i,
  input  logic       win32_i,
  input  oreg_t      outer3_i,
  input  logic       cpu_a14_i,
  input  logic       cpu_a13_i,
  output bank_t      bank_o
);
  bank_t outer_part;
  bank_t low_part;

  always_comb begin
    outer_part = bank_t'({base_i[NIB_W-1:0], {BASE_SH{1'b0}}}) & ~mask_i;
    low_part   = '0;
    if (gnrom_i) begin
      low_part[0]   = cpu_a13_i;
      low_part[3:1] = win32_i ? {outer3_i[3:2], cpu_a14_i} : outer3_i[3:1];
    end
    bank_o = outer_part | (inner_i & mask_i) | low_part;
  end

  always_comb begin
    if (!$isunknown({gnrom_i, cpu_a13_i, bank_o}) && gnrom_i)
      assert_a13_passthru_R7: assert (bank_o[0] == cpu_a13_i);
    if (!$isunknown({gnrom_i, win32_i, outer3_i, cpu_a14_i, bank_o}) && gnrom_i && win32_i)
      assert_win32_low_R5: assert (bank_o[3:1] == {outer3_i[3:2], cpu_a14_i});
    if (!$isunknown({gnrom_i, win32_i, outer3_i, bank_o}) && gnrom_i && !win32_i)
      assert_win16_low_R6: assert (bank_o[3:1] == outer3_i[3:1]);
  end

  logic unused_merge_bits;
  assign unused_merge_bits = ^{base_i[7:NIB_W], outer3_i[7:4], outer3_i[0]};
endmodule

// File: rtl/prg_bank_gen.sv
module prg_bank_gen
  import prg_bank_pkg::*;
#(
  parameter bit SWAP_EN = 1'b1
) (
  input  logic       cpu_a14_i,
  input  logic       cpu_a13_i,
  input  logic [7:0] inner_bank_i,
  input  logic       cmd_b6_i,
  input  logic [7:0] outer0_i,
  input  logic [7:0] outer1_i,
  input  logic [7:0] outer2_i,
  input  logic [7:0] outer3_i,
  output logic [7:0] bank_o
);
  logic       gnrom;
  bank_t      mask;
  logic [7:0] base;
  bank_t      inner_eff;

  assign gnrom = outer3_i[4];

  generate
    if (SWAP_EN) begin : g_swap
      logic swap_hit;
      // last two banks remapped to the first two in the upper half
      assign swap_hit  = outer3_i[6] && !cmd_b6_i && cpu_a14_i &&
                         (inner_bank_i[BANK_W-1:1] == {(BANK_W-1){1'b1}});
      assign inner_eff = swap_hit ? bank_t'(inner_bank_i[0]) : inner_bank_i;
    end else begin : g_noswap
      logic unused_swap;
      assign unused_swap = ^{cmd_b6_i};
      assign inner_eff   = inner_bank_i;
    end
  endgenerate

  prg_mask_gen u_mask (
    .outer0_i (outer0_i),
    .outer1_i (outer1_i),
    .gnrom_i  (gnrom),
    .mask_o   (mask)
  );

  prg_base_pack u_base (
    .outer0_i (outer0_i),
    .outer1_i (outer1_i),
    .base_o   (base)
  );

  prg_bank_merge u_merge (
    .base_i    (base),
    .mask_i    (mask),
    .inner_i   (inner_eff),
    .gnrom_i   (gnrom),
    .win32_i   (outer1_i[1]),
    .outer3_i  (outer3_i),
    .cpu_a14_i (cpu_a14_i),
    .cpu_a13_i (cpu_a13_i),
    .bank_o    (bank_o)
  );

  always_comb begin
    if (!$isunknown(mask))
      assert_mask_low_ones_R1: assert (gnrom || mask[3:0] == 4'hF);
    if (!$isunknown({gnrom, mask, inner_eff, bank_o}) && !gnrom)
      assert_inner_follow_R3: assert (((bank_o ^ inner_eff) & mask) == '0);
    if (!$isunknown({gnrom, mask}) && gnrom)
      assert_gnrom_mask_R4: assert (mask[3:0] == 4'h0);
    if (!$isunknown({cpu_a14_i, inner_eff, inner_bank_i}) && !cpu_a14_i)
      assert_swap_low_half_R9: assert (inner_eff == inner_bank_i);
  end

  logic unused_top;
  assign unused_top = ^{outer2_i, outer3_i[7], outer3_i[5]};
endmodule

// File: tb/prg_bank_gen_test.sv
module prg_bank_gen_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       a14, a13, cmd6;
  logic [7:0] inner, r0, r1, r2, r3;
  logic [7:0] bank;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  prg_bank_gen uut (
    .cpu_a14_i(a14), .cpu_a13_i(a13), .inner_bank_i(inner), .cmd_b6_i(cmd6),
    .outer0_i(r0), .outer1_i(r1), .outer2_i(r2), .outer3_i(r3), .bank_o(bank)
  );

  function automatic logic [7:0] model();
    logic [7:0] m, v, b, o;
    m = {r1[5], r1[6], ~r1[7], ~r0[6], 4'hF};
    v = inner;
    if (r3[6] && !cmd6 && a14 && inner >= 8'hFE) v = {7'b0, inner[0]};
    o = {r1[4], r0[2:0], 4'b0};
    if (r3[4]) begin
      m = m & 8'hF0;
      b = (o & ~m) | (v & m);
      b[0] = a13;
      if (r1[1]) b[3:1] = {r3[3:2], a14}; else b[3:1] = r3[3:1];
    end else b = (o & ~m) | (v & m);
    return b;
  endfunction

  task automatic apply(input logic [7:0] i0, i1, i3, iv, input logic ia14, ia13, ic6);
    @(negedge clk);
    r0 = i0; r1 = i1; r3 = i3; inner = iv; a14 = ia14; a13 = ia13; cmd6 = ic6;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (bank !== exp) begin
      errors++;
      $display("FAIL %s: bank=%02h expected=%02h", req, bank, exp);
    end
  endtask

  task automatic t_reset_state();
    apply(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R3 idle", 8'h00);
  endtask

  task automatic t_mask_bits();
    apply(8'h00, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b0, 1'b0); check("R1 base mask", 8'h1A);
    apply(8'h07, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); check("R2 base nibble", 8'hC0);
    apply(8'h07, 8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); check("R1 bit5 cleared", 8'hE0);
    apply(8'h47, 8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); check("R1 bit4 cleared", 8'hF0);
    apply(8'h07, 8'h70, 8'h00, 8'h12, 1'b0, 1'b0, 1'b0); check("R3 full mask", 8'h12);
    apply(8'h38, 8'h0C, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); check("R2 upper base dropped", 8'h00);
  endtask

  task automatic t_gnrom();
    apply(8'h07, 8'h10, 8'h1E, 8'h20, 1'b0, 1'b1, 1'b0); check("R6 16K window", 8'hEF);
    apply(8'h07, 8'h12, 8'h1C, 8'h20, 1'b0, 1'b0, 1'b0); check("R5 32K a14=0", 8'hEC);
    apply(8'h07, 8'h12, 8'h1C, 8'h20, 1'b1, 1'b0, 1'b0); check("R5 32K a14=1", 8'hEE);
    apply(8'h00, 8'h00, 8'h10, 8'hFF, 1'b1, 1'b0, 1'b0); check("R4 low bits masked", 8'h30);
    apply(8'h00, 8'h00, 8'h10, 8'hFF, 1'b1, 1'b1, 1'b0); check("R7 a13", 8'h31);
  endtask

  task automatic t_swap();
    apply(8'h00, 8'h00, 8'h40, 8'hFE, 1'b1, 1'b0, 1'b0); check("R8 FE remap", 8'h00);
    apply(8'h00, 8'h00, 8'h40, 8'hFF, 1'b1, 1'b1, 1'b0); check("R8 FF remap", 8'h01);
    apply(8'h00, 8'h00, 8'h40, 8'hFE, 1'b0, 1'b0, 1'b0); check("R9 low half", 8'h3E);
    apply(8'h00, 8'h00, 8'h40, 8'hFE, 1'b1, 1'b0, 1'b1); check("R9 cmd bit6", 8'h3E);
    apply(8'h00, 8'h00, 8'h40, 8'hFD, 1'b1, 1'b0, 1'b0); check("R9 below FE", 8'h3D);
    apply(8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0); check("R9 swap off", 8'h3F);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 512; k++) begin
      apply(8'((k * 37) ^ 8'h5C), 8'((k * 91) + 3), 8'((k * 13) ^ (k >> 3)),
            8'(k * 29 + (k >> 5)), k[0], k[1], k[2]);
      check("R3 sweep model", model());
    end
  endtask

  initial begin
    r2 = 8'hA5;
    t_reset_state();
    t_mask_bits();
    t_gnrom();
    t_swap();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: bank=%02h expected=done", bank);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule